// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous Memory

This block is a synthesizable behavioural model of a synchronous static memory with a two-phase access. An address and its control are captured on one rising clock edge. The data word for that access moves during the next cycle. Writes are late: the word on the input bus is taken at the end of its data cycle and held in a pending-write register. That register is committed to the array on the following active edge. Because of this, reads and writes can alternate in any order on every cycle, with no idle cycle between them.

Read data is flow-through. It is not registered on the way out, so it is valid during the data cycle, combinationally, from the location captured one edge earlier. A read that hits the location still held in the pending-write register takes the enabled lanes of that register's data. A clock-hold input freezes the whole block. Three chip selects of mixed polarity gate the start of new accesses. A sleep input blocks new accesses and turns the output drivers off. An asynchronous output enable can turn the drivers off at any time. The advance/load strobe can also continue a four-word linear burst from the previous access.

Top module: `ftzt_sram`

## Requirements
- R1: A read captured on an edge (rst released, `hold_i`=0, `sleep_i`=0, `sel_a_ni`=0, `sel_b_i`=1, `sel_c_ni`=0, `ld_adv_i`=0, `rd_wr_ni`=1) presents the word at the captured address on `dq_o` with `dq_oe_o`=1 during the following cycle, provided `oe_ni`=0.
- R2: A write is captured the same way with `rd_wr_ni`=0. The word on `dq_i` during the following cycle, sampled at the edge that ends that cycle, is stored, and a later read returns it.
- R3: Reads and writes may alternate on consecutive edges with no idle cycle. A read captured on the edge right after a write to the same address returns the newly written data.
- R4: `lane_wr_ni` is active low and is captured with the address. Bit i low writes `dq_i[9i+8:9i]`, and lanes whose bit is high keep their old content. This also applies to data forwarded to a read that follows at once.
- R5: While `hold_i`=1, every synchronous input is ignored and all state, `dq_o` included, keeps its value. When `hold_i` returns to 0, the held access completes normally.
- R6: A new access starts only when `sel_a_ni`=0, `sel_b_i`=1, `sel_c_ni`=0 and `ld_adv_i`=0. Otherwise nothing new starts, but a write captured on the previous edge still stores its data.
- R7: `dq_oe_o` is 0 after reset, and it is 0 in the cycle after an edge that deselected the block or captured a write.
- R8: `oe_ni`=1 forces `dq_oe_o` to 0 at once, without waiting for a clock edge.
- R9: While `sleep_i`=1, no new access starts, and `dq_oe_o` is 0 at once.
- R10: `ld_adv_i`=1 on an edge whose previous cycle held an access continues that access in the same direction and with the same lane enables. The address's low two bits are incremented modulo 4 and the upper bits are kept. `ld_adv_i`=1 after an idle cycle starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_i | input | 1 | Clock hold: 1 freezes all synchronous behaviour |
| sel_a_ni | input | 1 | Chip select A, active low |
| sel_b_i | input | 1 | Chip select B, active high |
| sel_c_ni | input | 1 | Chip select C, active low |
| ld_adv_i | input | 1 | 0 loads a new access, 1 advances the burst |
| rd_wr_ni | input | 1 | 1 read, 0 write |
| lane_wr_ni | input | LANES | Per-lane write enables, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep: blocks new accesses, drivers off |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | LANES*LANE_W | Write data bus |
| dq_o | output | LANES*LANE_W | Flow-through read data |
| dq_oe_o | output | 1 | Output driver enable for the data bus |

## Verification
The bench builds the block with its defaults: 16 words, four 9-bit lanes, 4-bit address. The small depth puts a burst wrap from address 14 through 15 back to 12 within a handful of cycles. It also allows every forwarding case, full-word and single-lane, to be checked against a shadow model in the bench. The four lanes of nine bits let a partial write be checked lane by lane. This includes a merge between the pending register and an older array word that a following read must see.

// File: rtl/ftzt_pkg.sv
package ftzt_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;

  // advance the low two address bits modulo four, keep the rest
  function automatic logic [1:0] wrap_step(input logic [1:0] lo);
    return lo + 2'd1;
  endfunction

endpackage

// File: rtl/ftzt_ctrl.sv
module ftzt_ctrl #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              sel_ok_i,
  input  logic              ld_adv_i,
  input  logic              rd_wr_ni,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_wr_ni,
  output logic              stg_vld_o,
  output ftzt_pkg::dir_e    stg_dir_o,
  output logic [ADDR_W-1:0] stg_addr_o,
  output logic [LANES-1:0]  stg_lane_o
);
  import ftzt_pkg::*;

  logic              vld_q, vld_d;
  dir_e              dir_q, dir_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LANES-1:0]  lane_q, lane_d;

  always_comb begin
    vld_d  = 1'b0;
    dir_d  = dir_q;
    addr_d = addr_q;
    lane_d = lane_q;
    if (!sleep_i && !ld_adv_i && sel_ok_i) begin
      vld_d  = 1'b1;
      dir_d  = rd_wr_ni ? DIR_RD : DIR_WR;
      addr_d = addr_i;
      lane_d = ~lane_wr_ni;
    end else if (!sleep_i && ld_adv_i && vld_q) begin
      vld_d      = 1'b1;
      addr_d[1:0] = wrap_step(addr_q[1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      dir_q  <= DIR_RD;
      addr_q <= '0;
      lane_q <= '0;
    end else if (!hold_i) begin
      vld_q  <= vld_d;
      dir_q  <= dir_d;
      addr_q <= addr_d;
      lane_q <= lane_d;
    end
  end

  assign stg_vld_o  = vld_q;
  assign stg_dir_o  = dir_q;
  assign stg_addr_o = addr_q;
  assign stg_lane_o = lane_q;
endmodule

// File: rtl/ftzt_wbuf.sv
module ftzt_wbuf #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              stg_vld_i,
  input  ftzt_pkg::dir_e    stg_dir_i,
  input  logic [ADDR_W-1:0] stg_addr_i,
  input  logic [LANES-1:0]  stg_lane_i,
  input  logic [DW-1:0]     dq_i,
  input  logic [DW-1:0]     arr_rd_i,
  output logic              pnd_vld_o,
  output logic [ADDR_W-1:0] pnd_addr_o,
  output logic [LANES-1:0]  pnd_lane_o,
  output logic [DW-1:0]     pnd_data_o,
  output logic [DW-1:0]     rd_data_o
);
  import ftzt_pkg::*;

  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LANES-1:0]  lane_q, lane_d;
  logic [DW-1:0]     data_q, data_d;
  logic              hit;

  always_comb begin
    vld_d  = stg_vld_i && (stg_dir_i == DIR_WR);
    addr_d = stg_addr_i;
    lane_d = stg_lane_i;
    data_d = dq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      lane_q <= '0;
      data_q <= '0;
    end else if (!hold_i) begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
      lane_q <= lane_d;
      data_q <= data_d;
    end
  end

  assign hit = vld_q && (addr_q == stg_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign rd_data_o[l*LANE_W +: LANE_W] = (hit && lane_q[l]) ?
        data_q[l*LANE_W +: LANE_W] : arr_rd_i[l*LANE_W +: LANE_W];
  end

  assign pnd_vld_o  = vld_q;
  assign pnd_addr_o = addr_q;
  assign pnd_lane_o = lane_q;
  assign pnd_data_o = data_q;
endmodule

// File: rtl/ftzt_array.sv
module ftzt_array #(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DW     = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LANES-1:0]  wlane_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DW-1:0]     rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wlane_i[l]) begin
        mem_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/ftzt_sram.sv
module ftzt_sram #(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DW     = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              sel_a_ni,
  input  logic              sel_b_i,
  input  logic              sel_c_ni,
  input  logic              ld_adv_i,
  input  logic              rd_wr_ni,
  input  logic [LANES-1:0]  lane_wr_ni,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     dq_i,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o
);
  import ftzt_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              sel_ok;
  logic              stg_vld;
  dir_e              stg_dir;
  logic [ADDR_W-1:0] stg_addr;
  logic [LANES-1:0]  stg_lane;
  logic              pnd_vld;
  logic [ADDR_W-1:0] pnd_addr;
  logic [LANES-1:0]  pnd_lane;
  logic [DW-1:0]     pnd_data;
  logic [DW-1:0]     arr_rd;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign sel_ok = !sel_a_ni && sel_b_i && !sel_c_ni;

  ftzt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .hold_i     (hold_i),
    .sel_ok_i   (sel_ok),
    .ld_adv_i   (ld_adv_i),
    .rd_wr_ni   (rd_wr_ni),
    .sleep_i    (sleep_i),
    .addr_i     (addr_i),
    .lane_wr_ni (lane_wr_ni),
    .stg_vld_o  (stg_vld),
    .stg_dir_o  (stg_dir),
    .stg_addr_o (stg_addr),
    .stg_lane_o (stg_lane)
  );

  ftzt_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) wbuf_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .hold_i     (hold_i),
    .stg_vld_i  (stg_vld),
    .stg_dir_i  (stg_dir),
    .stg_addr_i (stg_addr),
    .stg_lane_i (stg_lane),
    .dq_i       (dq_i),
    .arr_rd_i   (arr_rd),
    .pnd_vld_o  (pnd_vld),
    .pnd_addr_o (pnd_addr),
    .pnd_lane_o (pnd_lane),
    .pnd_data_o (pnd_data),
    .rd_data_o  (dq_o)
  );

  ftzt_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk_i   (clk_i),
    .we_i    (pnd_vld && !hold_i),
    .waddr_i (pnd_addr),
    .wlane_i (pnd_lane),
    .wdata_i (pnd_data),
    .raddr_i (stg_addr),
    .rdata_o (arr_rd)
  );

  assign dq_oe_o = stg_vld && (stg_dir == DIR_RD) && !oe_ni && !sleep_i;
endmodule

// File: rtl/ftzt_sram_chk.sv
module ftzt_sram_chk #(
  parameter int ADDR_W = 4,
  parameter int DW     = 36
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hold_i,
  input logic          sel_a_ni,
  input logic          sel_b_i,
  input logic          sel_c_ni,
  input logic          ld_adv_i,
  input logic          rd_wr_ni,
  input logic          oe_ni,
  input logic          sleep_i,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe_o
);
  logic sel_all;
  logic start_any;
  assign sel_all   = !sel_a_ni && sel_b_i && !sel_c_ni;
  assign start_any = !hold_i && !sleep_i && !ld_adv_i && sel_all;

  // R1
  rd_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_any && rd_wr_ni) |=> (dq_oe_o || oe_ni || sleep_i));

  // R7
  wr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_any && !rd_wr_ni) |=> !dq_oe_o);

  // R7
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !ld_adv_i && !sel_all) |=> !dq_oe_o);

  // R5
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(dq_o));

  // R8
  oe_async_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);

  // R9
  sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o);
endmodule

bind ftzt_sram ftzt_sram_chk #(.ADDR_W(ADDR_W), .DW(DW)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_sync_n),
  .hold_i   (hold_i),
  .sel_a_ni (sel_a_ni),
  .sel_b_i  (sel_b_i),
  .sel_c_ni (sel_c_ni),
  .ld_adv_i (ld_adv_i),
  .rd_wr_ni (rd_wr_ni),
  .oe_ni    (oe_ni),
  .sleep_i  (sleep_i),
  .dq_o     (dq_o),
  .dq_oe_o  (dq_oe_o)
);

// File: tb/ftzt_sram_tb_top.sv
module ftzt_sram_tb_top;
  localparam int AW = 4;
  localparam int DW = 36;
  localparam int K_IDLE = 0, K_RD = 1, K_WR = 2, K_ADV = 3;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          hold_i, sel_a_ni, sel_b_i, sel_c_ni, ld_adv_i, rd_wr_ni;
  logic [3:0]    lane_wr_ni;
  logic          oe_ni, sleep_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] dq_i, dq_o;
  logic          dq_oe_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ftzt_sram dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hold_i(hold_i),
    .sel_a_ni(sel_a_ni), .sel_b_i(sel_b_i), .sel_c_ni(sel_c_ni),
    .ld_adv_i(ld_adv_i), .rd_wr_ni(rd_wr_ni), .lane_wr_ni(lane_wr_ni),
    .oe_ni(oe_ni), .sleep_i(sleep_i), .addr_i(addr_i), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [3:0] ln_n);
    logic [DW-1:0] r = old_w;
    for (int l = 0; l < 4; l++) if (!ln_n[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
    return r;
  endfunction

  // drive one edge: control for the next capture, dq_i for the current data cycle
  task automatic issue(input int kind, input logic [AW-1:0] a, input logic [3:0] ln_n,
                       input logic [DW-1:0] wd, input logic [2:0] sel = 3'b010);
    sel_a_ni   = sel[2];
    sel_b_i    = (kind == K_IDLE) ? 1'b0 : sel[1];
    sel_c_ni   = sel[0];
    ld_adv_i   = (kind == K_ADV);
    rd_wr_ni   = (kind != K_WR);
    addr_i     = a;
    lane_wr_ni = ln_n;
    dq_i       = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R7 reset oe", {35'd0, dq_oe_o}, 36'd0);
  endtask

  task automatic t_basic;
    issue(K_WR, 0, 4'h0, '0);
    issue(K_WR, 1, 4'h0, 36'h1_1111_1110);
    issue(K_WR, 2, 4'h0, 36'h2_2222_2221);
    issue(K_IDLE, 0, 4'h0, 36'h3_3333_3332);
    issue(K_IDLE, 0, 4'h0, '0);
    issue(K_RD, 0, 4'hF, '0);
    chk("R1 oe", {35'd0, dq_oe_o}, 36'd1);
    chk("R2 word0", dq_o, 36'h1_1111_1110);
    issue(K_RD, 1, 4'hF, '0);
    chk("R2 word1", dq_o, 36'h2_2222_2221);
    issue(K_RD, 2, 4'hF, '0);
    chk("R1 word2", dq_o, 36'h3_3333_3332);
    issue(K_IDLE, 0, 4'hF, '0);
    chk("R7 deselect oe", {35'd0, dq_oe_o}, 36'd0);
  endtask

  task automatic t_alternate;
    issue(K_WR, 5, 4'h0, '0);
    chk("R7 write oe", {35'd0, dq_oe_o}, 36'd0);
    issue(K_RD, 5, 4'hF, 36'hE_0E0E_0E0E);
    chk("R3 fwd oe", {35'd0, dq_oe_o}, 36'd1);
    chk("R3 fwd data", dq_o, 36'hE_0E0E_0E0E);
    issue(K_WR, 6, 4'h0, '0);
    chk("R3 write after read oe", {35'd0, dq_oe_o}, 36'd0);
    issue(K_RD, 6, 4'hF, 36'hF_00F0_0F00);
    chk("R3 read after write", dq_o, 36'hF_00F0_0F00);
    issue(K_RD, 5, 4'hF, '0);
    chk("R3 older word", dq_o, 36'hE_0E0E_0E0E);
  endtask

  task automatic t_lanes;
    logic [DW-1:0] g = 36'h5_5555_5555;
    logic [DW-1:0] h = 36'hA_AAAA_AAAA;
    logic [DW-1:0] k = 36'h1_2345_6789;
    logic [DW-1:0] m = 36'hF_EDCB_A987;
    issue(K_WR, 7, 4'h0, '0);
    issue(K_IDLE, 0, 4'h0, g);
    issue(K_WR, 7, 4'b1010, '0);
    issue(K_IDLE, 0, 4'h0, h);
    issue(K_RD, 7, 4'hF, '0);
    chk("R4 lanes 0,2", dq_o, merge(g, h, 4'b1010));
    issue(K_WR, 8, 4'h0, '0);
    issue(K_IDLE, 0, 4'h0, k);
    issue(K_WR, 8, 4'b0111, '0);
    issue(K_RD, 8, 4'hF, m);
    chk("R4 forwarded lane 3", dq_o, merge(k, m, 4'b0111));
  endtask

  task automatic t_select;
    issue(K_WR, 9, 4'h0, '0);
    issue(K_IDLE, 0, 4'h0, 36'h9_8765_4321);
    chk("R6 deselect oe", {35'd0, dq_oe_o}, 36'd0);
    issue(K_WR, 9, 4'h0, '0, 3'b110);
    issue(K_WR, 9, 4'h0, 36'hD_EADD_EADD, 3'b000);
    issue(K_WR, 9, 4'h0, 36'hB_ADBA_DBAD, 3'b011);
    issue(K_IDLE, 0, 4'h0, 36'hC_CCCC_CCCC);
    issue(K_RD, 9, 4'hF, '0);
    chk("R6 rejected writes", dq_o, 36'h9_8765_4321);
  endtask

  task automatic t_hold;
    issue(K_WR, 10, 4'h0, '0);
    hold_i = 1'b1;
    issue(K_WR, 11, 4'h0, 36'h0_BAD0_BAD0);
    hold_i = 1'b0;
    issue(K_IDLE, 0, 4'h0, 36'h4_4444_0001);
    issue(K_RD, 10, 4'hF, '0);
    chk("R5 held write", dq_o, 36'h4_4444_0001);
    hold_i = 1'b1;
    issue(K_RD, 11, 4'hF, '0);
    chk("R5 held read oe", {35'd0, dq_oe_o}, 36'd1);
    chk("R5 held read data", dq_o, 36'h4_4444_0001);
    hold_i = 1'b0;
    issue(K_IDLE, 0, 4'hF, '0);
    chk("R5 after release", {35'd0, dq_oe_o}, 36'd0);
  endtask

  task automatic t_oe;
    issue(K_RD, 0, 4'hF, '0);
    oe_ni = 1'b1;
    #0.5;
    chk("R8 oe off", {35'd0, dq_oe_o}, 36'd0);
    oe_ni = 1'b0;
    #0.5;
    chk("R8 oe on", {35'd0, dq_oe_o}, 36'd1);
  endtask

  task automatic t_sleep;
    issue(K_RD, 1, 4'hF, '0);
    sleep_i = 1'b1;
    #0.5;
    chk("R9 sleep drivers", {35'd0, dq_oe_o}, 36'd0);
    issue(K_WR, 1, 4'h0, '0);
    issue(K_IDLE, 0, 4'h0, 36'h0_DEAD_0000);
    sleep_i = 1'b0;
    issue(K_RD, 1, 4'hF, '0);
    chk("R9 no write in sleep", dq_o, 36'h2_2222_2221);
  endtask

  task automatic t_burst;
    issue(K_WR, 14, 4'h0, '0);
    issue(K_ADV, 0, 4'hF, 36'h0_0000_0E0E);
    issue(K_ADV, 0, 4'hF, 36'h0_0000_0F0F);
    issue(K_IDLE, 0, 4'hF, 36'h0_0000_0C0C);
    issue(K_RD, 14, 4'hF, '0);
    chk("R10 first", dq_o, 36'h0_0000_0E0E);
    issue(K_ADV, 3, 4'h0, '0);
    chk("R10 step 15", dq_o, 36'h0_0000_0F0F);
    issue(K_ADV, 3, 4'h0, '0);
    chk("R10 wrap 12", dq_o, 36'h0_0000_0C0C);
    issue(K_IDLE, 0, 4'hF, '0);
    issue(K_ADV, 0, 4'hF, '0);
    chk("R10 advance from idle", {35'd0, dq_oe_o}, 36'd0);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_ni = 1'b0; hold_i = 1'b0; sel_a_ni = 1'b1; sel_b_i = 1'b0; sel_c_ni = 1'b1;
    ld_adv_i = 1'b0; rd_wr_ni = 1'b1; lane_wr_ni = 4'hF; oe_ni = 1'b0; sleep_i = 1'b0;
    addr_i = '0; dq_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_basic();
    t_alternate();
    t_lanes();
    t_select();
    t_hold();
    t_oe();
    t_sleep();
    t_burst();
    report();
  end
endmodule